// File: doc/BRIEF.md
# Single-Channel PWM Timer with Binary Prescaler

This block produces one pulse-width-modulated output from two 32-bit registers written over a plain register port. A power-of-two prescaler divides the core clock into ticks. A 10-bit counter walks through a period measured in ticks. The output is high for the first part of each period, which the phase count sets, and low for the rest.

The divide exponent is split across two control fields. One bit carries its least significant bit, and a 4-bit field carries the remaining bits. Every configuration write first lands in the readable staged registers. It is copied to the active registers only when no hold is requested and the channel is idle or at a period boundary, so a running waveform never shows a partial period.

Software raises the hold bit, rewrites the divider and counts, then drops the hold bit. All the new values then take effect together at the next boundary. A zero period or a zero phase is a forbidden setting: the channel keeps its output low.

Top module: `pwmt_top`

## Requirements
- R1: After reset the output is low and both registers read as zero.
- R2: Address bit 2 selects the register: 0 is control, 1 is counts. Control bits are: enable at 0, a spare select flag at 4, hold at 11, divider low bit at 15, and divider upper bits at 19:16. The counts register holds the period in bits 25:16 and the phase in bits 9:0. A read returns the last written value, with every other bit reading zero.
- R3: While running with active period P, phase H and divider D, the output at clock t after enable equals ((t >> D) mod P) < H.
- R4: When H >= P, the output stays high for the whole period.
- R5: With enable set and an active period or phase of zero, the output stays low and the counter stays at zero.
- R6: Clearing enable drives the output low on the next cycle. Setting it again starts a fresh period, with the output high in the first cycle.
- R7: The divide exponent is D = {ctrl[19:16], ctrl[15]}. A value above MAX_DIV is clamped to MAX_DIV when it becomes active.
- R8: While the hold bit is set, the active period, phase and divider do not change. After the hold bit is cleared, pending values take effect at the next period boundary.
- R9: A write while running takes effect only at a period boundary. A write captured on the same edge as a boundary waits for the following boundary.
- R10: While the channel is idle, a write becomes active on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; bit 2 selects the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at addr |
| pwm_out | output | 1 | PWM waveform |

## Verification
The delicate coincidence is a register write landing on the same edge as a period boundary. On that edge an older pending update may commit while the new write re-arms the pending flag. The bench enables a 4-tick period, places a counts write exactly on the first boundary edge, and checks every cycle of the next two periods. The old pattern must persist for one more period, and the new one must appear only at the second boundary. A held update released while the counter is running is judged by counting high cycles over whole periods of the old and the new setting.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int REG_W    = 32;
  localparam int CNT_W    = 10;
  localparam int DIV_W    = 5;
  localparam int EN_BIT   = 0;
  localparam int SEL_BIT  = 4;
  localparam int SYNC_BIT = 11;
  localparam int DLO_BIT  = 15;
  localparam int DHI_LSB  = 16;
  localparam int PER_LSB  = 16;
  localparam int PH_LSB   = 0;
  localparam int WSEL_BIT = 2;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h000F_8811;
  localparam logic [REG_W-1:0] CNT_MASK  = 32'h03FF_03FF;

  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] ph;
    logic [DIV_W-1:0] div;
  } pwmt_cfg_t;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              en,
  output logic              hold,
  output pwmt_cfg_t         staged,
  output logic              cfg_wr
);
  logic             en_q, sel_q, hold_q, dlo_q;
  logic [3:0]       dhi_q;
  logic [CNT_W-1:0] per_q, ph_q;
  logic             is_cnt;

  assign is_cnt = addr[WSEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      hold_q <= 1'b0;
      dlo_q  <= 1'b0;
      dhi_q  <= '0;
      per_q  <= '0;
      ph_q   <= '0;
    end else if (wr_en) begin
      if (is_cnt) begin
        per_q <= wdata[PER_LSB +: CNT_W];
        ph_q  <= wdata[PH_LSB +: CNT_W];
      end else begin
        en_q   <= wdata[EN_BIT];
        sel_q  <= wdata[SEL_BIT];
        hold_q <= wdata[SYNC_BIT];
        dlo_q  <= wdata[DLO_BIT];
        dhi_q  <= wdata[DHI_LSB +: 4];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (is_cnt) begin
      rdata[PER_LSB +: CNT_W] = per_q;
      rdata[PH_LSB +: CNT_W]  = ph_q;
    end else begin
      rdata[EN_BIT]       = en_q;
      rdata[SEL_BIT]      = sel_q;
      rdata[SYNC_BIT]     = hold_q;
      rdata[DLO_BIT]      = dlo_q;
      rdata[DHI_LSB +: 4] = dhi_q;
    end
  end

  assign en         = en_q;
  assign hold       = hold_q;
  assign staged.per = per_q;
  assign staged.ph  = ph_q;
  assign staged.div = {dhi_q, dlo_q};
  assign cfg_wr     = wr_en;

  logic unused_bits;
  assign unused_bits = ^{wdata & ~(CTRL_MASK | CNT_MASK), addr};
endmodule

// File: rtl/pwmt_commit.sv
module pwmt_commit
  import pwmt_pkg::*;
#(
  parameter int MAX_DIV = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pwmt_cfg_t staged,
  input  logic      cfg_wr,
  input  logic      hold,
  input  logic      idle,
  input  logic      boundary,
  output pwmt_cfg_t active,
  output logic      commit
);
  localparam logic [DIV_W-1:0] DIV_CAP = DIV_W'(MAX_DIV);

  logic      pend_q;
  pwmt_cfg_t act_q;
  logic [DIV_W-1:0] div_cl;

  assign div_cl = (staged.div > DIV_CAP) ? DIV_CAP : staged.div;
  assign commit = pend_q && !hold && (idle || boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= '0;
    end else begin
      if (cfg_wr)      pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;
      if (commit) begin
        act_q.per <= staged.per;
        act_q.ph  <= staged.ph;
        act_q.div <= div_cl;
      end
    end
  end

  assign active = act_q;
endmodule

// File: rtl/pwmt_prescale.sv
module pwmt_prescale
  import pwmt_pkg::*;
#(
  parameter int MAX_DIV = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PW = (MAX_DIV > 0) ? MAX_DIV : 1;

  logic [PW-1:0] pre_q, mask;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (32'(i) < 32'(div));
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr)   pre_q <= '0;
    else if (tick)  pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwmt_count.sv
module pwmt_count
  import pwmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] ph,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary,
  output logic             wave
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = (cnt_q == per - CNT_W'(1));
  assign boundary = run && tick && last;
  assign wave     = run && (cnt_q < ph);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || restart) cnt_q <= '0;
    else if (tick)           cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int MAX_DIV = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              pwm_out
);
  logic             en, hold, cfg_wr, commit, run, tick, boundary;
  pwmt_cfg_t        staged, active;
  logic [CNT_W-1:0] cnt;

  pwmt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .en(en), .hold(hold), .staged(staged), .cfg_wr(cfg_wr)
  );

  assign run = en && (active.per != '0) && (active.ph != '0);

  pwmt_commit #(.MAX_DIV(MAX_DIV)) u_commit (
    .clk(clk), .rst_n(rst_n), .staged(staged), .cfg_wr(cfg_wr), .hold(hold),
    .idle(!run), .boundary(boundary), .active(active), .commit(commit)
  );

  pwmt_prescale #(.MAX_DIV(MAX_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!run || commit), .run(run),
    .div(active.div), .tick(tick)
  );

  pwmt_count u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .restart(commit),
    .per(active.per), .ph(active.ph), .cnt(cnt), .boundary(boundary),
    .wave(pwm_out)
  );
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk
  import pwmt_pkg::*;
#(
  parameter int MAX_DIV = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             hold,
  input logic             commit,
  input pwmt_cfg_t        active,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      rdata,
  input logic             pwm_out
);
  // R5
  forbid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (active.per == '0 || active.ph == '0)) |-> (!pwm_out && cnt == '0));
  // R6
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);
  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(active));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active.per != '0 && active.ph != '0) |-> (cnt < active.per));
  // R7
  div_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(active.div) <= MAX_DIV);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~(CTRL_MASK | CNT_MASK)) == '0);
  // R9
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && en && active.per != '0 && active.ph != '0) |-> (cnt == active.per - CNT_W'(1)));
endmodule

bind pwmt_top pwmt_chk #(.MAX_DIV(MAX_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .hold(hold), .commit(commit),
  .active(active), .cnt(cnt), .rdata(rdata), .pwm_out(pwm_out)
);

// File: tb/tb_pwmt_top.sv
`timescale 1ns/1ps
module tb_pwmt_top;
  localparam int MAXD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwmt_top #(.ADDR_W(3), .MAX_DIV(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] ctrl(input bit en, input bit hold, input int d);
    return (32'(en)) | (32'(hold) << 11) | (32'(d & 1) << 15) | (32'((d >> 1) & 15) << 16);
  endfunction

  function automatic logic [31:0] cntw(input int p, input int h);
    return (32'(p & 1023) << 16) | 32'(h & 1023);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  // R3 R4 R7: enable a configuration and compare every cycle of two periods
  task automatic run_cfg(input string req, input int p, input int h, input int dw, input int de);
    int bad = 0;
    logic got = 1'b0, want = 1'b0;
    wr(3'h0, ctrl(0, 0, dw));
    wr(3'h4, cntw(p, h));
    @(negedge clk); @(negedge clk);
    wr(3'h0, ctrl(1, 0, dw));
    for (int t = 0; t < 2 * p * (1 << de); t++) begin
      logic e;
      e = (((t >> de) % p) < h);
      if (pwm_out !== e && bad == 0) begin got = pwm_out; want = e; end
      if (pwm_out !== e) bad++;
      @(negedge clk);
    end
    check(req, {31'd0, (bad == 0) ? want : got}, {31'd0, want});
  endtask

  function automatic int highs_over(input int n);
    return n;
  endfunction

  initial begin
    logic [31:0] r;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 out", {31'd0, pwm_out}, 32'd0);
    rd(3'h0, r); check("R1 ctrl", r, 32'd0);
    rd(3'h4, r); check("R1 cnt", r, 32'd0);

    // R2 field masks
    wr(3'h0, 32'hFFFF_FFFF);
    rd(3'h0, r); check("R2 ctrl", r, 32'h000F_8811);
    wr(3'h4, 32'hFFFF_FFFF);
    rd(3'h4, r); check("R2 cnt", r, 32'h03FF_03FF);
    wr(3'h4, cntw(5, 2));
    rd(3'h4, r); check("R2 cnt fields", r, 32'h0005_0002);
    wr(3'h0, ctrl(0, 0, 3) | 32'h10);
    rd(3'h0, r); check("R2 ctrl fields", r, 32'h0001_8010);

    // R3 R4 sweep over period, phase and divider
    for (int d = 0; d < 4; d++)
      for (int p = 1; p <= 5; p++)
        for (int h = 1; h <= 6; h++)
          run_cfg((h >= p) ? "R4 sweep" : "R3 sweep", p, h, d, d);

    // R7 clamp: divider 7 acts as MAXD
    run_cfg("R7 clamp", 2, 1, 7, MAXD);

    // R5 forbidden zero period / zero phase
    for (int k = 0; k < 2; k++) begin
      wr(3'h0, ctrl(0, 0, 0));
      wr(3'h4, (k == 0) ? cntw(0, 3) : cntw(3, 0));
      @(negedge clk); @(negedge clk);
      wr(3'h0, ctrl(1, 0, 0));
      hi = 0;
      for (int t = 0; t < 20; t++) begin hi += pwm_out; @(negedge clk); end
      check("R5 forbidden low", 32'(hi), 32'd0);
    end

    // R6 disable and fresh restart
    wr(3'h0, ctrl(0, 0, 0));
    wr(3'h4, cntw(3, 1));
    @(negedge clk); @(negedge clk);
    wr(3'h0, ctrl(1, 0, 0));
    @(negedge clk);
    check("R6 mid period low", {31'd0, pwm_out}, 32'd0);
    wr(3'h0, ctrl(0, 0, 0));
    check("R6 disabled low", {31'd0, pwm_out}, 32'd0);
    wr(3'h0, ctrl(1, 0, 0));
    check("R6 fresh start high", {31'd0, pwm_out}, 32'd1);
    @(negedge clk);
    check("R6 fresh second low", {31'd0, pwm_out}, 32'd0);

    // R10 idle write active on next edge
    wr(3'h0, ctrl(0, 0, 0));
    wr(3'h4, cntw(4, 4));
    @(negedge clk); @(negedge clk);
    wr(3'h4, cntw(2, 1));
    wr(3'h0, ctrl(1, 0, 0));
    hi = 0;
    for (int t = 0; t < 4; t++) begin
      hi = hi | (32'(pwm_out) << t);
      @(negedge clk);
    end
    check("R10 idle update", 32'(hi), 32'h5);

    // R8 hold: staged values wait, then move at a boundary
    wr(3'h0, ctrl(0, 0, 0));
    wr(3'h4, cntw(4, 2));
    @(negedge clk); @(negedge clk);
    wr(3'h0, ctrl(1, 0, 0));
    wr(3'h0, ctrl(1, 1, 0));
    wr(3'h4, cntw(3, 1));
    repeat (20) @(negedge clk);
    hi = 0;
    for (int t = 0; t < 8; t++) begin hi += pwm_out; @(negedge clk); end
    check("R8 held old pattern", 32'(hi), 32'd4);
    wr(3'h0, ctrl(1, 0, 0));
    repeat (10) @(negedge clk);
    hi = 0;
    for (int t = 0; t < 9; t++) begin hi += pwm_out; @(negedge clk); end
    check("R8 released new pattern", 32'(hi), 32'd3);

    // R9 write on the boundary edge waits one more period
    wr(3'h0, ctrl(0, 0, 0));
    wr(3'h4, cntw(4, 1));
    @(negedge clk); @(negedge clk);
    wr(3'h0, ctrl(1, 0, 0));
    hi = 0;
    for (int t = 0; t < 4; t++) begin
      hi = hi | (32'(pwm_out) << t);
      if (t < 3) @(negedge clk);
    end
    wr(3'h4, cntw(2, 1));
    for (int t = 4; t < 12; t++) begin
      hi = hi | (32'(pwm_out) << t);
      @(negedge clk);
    end
    // expected t0..11: 1000 1000 1010
    check("R9 boundary write", 32'(hi), 32'h511);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule